// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked system and an asynchronous byte-wide static RAM with 20 address lines, an 8-bit data bus, a low-active and a high-active chip select, an output enable and a write enable. The system side offers one word per request over a request/ready handshake. Each accepted request becomes one complete memory cycle. Every phase is built from whole clock periods. The phase lengths are derived at elaboration from the clock period and the memory's timing figures in nanoseconds, rounded up.

A write raises output enable for the whole cycle. It sets up the address and chip selects, pulses write enable, and drives the data bus only after write enable is already low. The driver is released one clock after write enable returns high. A read holds the chip selected with output enable low for the access window, registers the returned byte on the last cycle, and flags it with a one-clock valid strobe. Every cycle ends with a single recovery clock in which the memory is deselected and all strobes are inactive. A standby input deselects the memory whenever the controller is idle, which puts the memory in its low-power state.

The data bus is split into an output value, a drive enable and an input value. A pad ring joins these into the bidirectional pins. With the default parameters (4 ns clock, 55 ns grade), a read occupies 14 access clocks and a write uses 3 setup clocks and a 10-clock write pulse.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held low across a clock edge, the memory is deselected (`mem_cs1_n`=1, `mem_cs2`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_drive`=0 and `rvalid`=0.
- R2: An accepted read (`wr`=0) holds `mem_cs1_n`=0, `mem_cs2`=1, `mem_we_n`=1, `mem_oe_n`=0 for the first 14 cycles after acceptance. `rvalid` is high for exactly the 15th cycle, and during that cycle `rdata` carries the byte the memory returned for the captured address.
- R3: An accepted write (`wr`=1) keeps `mem_oe_n`=1 throughout. `mem_we_n` is low for exactly cycles 4 to 13 after acceptance, and the chip is selected from cycle 1 through cycle 14.
- R4: `mem_dq_drive` is high only from the second write-enable-low cycle (cycle 5) through the cycle after write enable rises (cycle 14). It is never high while `mem_oe_n` is low, and never within 20 ns of the memory driving the bus.
- R5: Write data is driven at least 30 ns before write enable rises, the write pulse is at least 40 ns, and the written byte reads back unchanged.
- R6: `ready` falls on acceptance and stays low for 15 cycles. Cycle 15 is a recovery cycle with the memory deselected and `mem_oe_n`=`mem_we_n`=1. `ready` is high again in cycle 16 when standby is low.
- R7: While `standby` is high and no cycle is running, the memory is deselected and `ready` is low, and a request starts no cycle and writes nothing. Raising `standby` during a cycle lets that cycle finish unchanged, after which the memory is deselected.
- R8: Changes to `addr`, `wdata` and `wr` after acceptance have no effect on the running cycle.
- R9: While idle with `standby` low, the memory is selected with `mem_oe_n`=1 and `mem_we_n`=1, so it neither drives nor writes.
- R10: A write cycle never raises `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| standby | input | 1 | Deselect the memory while idle |
| req | input | 1 | Request a memory cycle |
| ready | output | 1 | Controller can accept a request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Word address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | One-clock strobe: rdata is valid |
| mem_addr | output | 20 | Memory address lines |
| mem_cs1_n | output | 1 | Low-active chip select |
| mem_cs2 | output | 1 | High-active chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Value to drive on the data bus |
| mem_dq_drive | output | 1 | Enable of the data bus driver |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
A wrong phase state or a mis-loaded phase timer appears at once as a strobe edge in the wrong cycle. The bench compares every control pin against its expected level in each of the 16 cycles after acceptance, so such a fault is reported in the cycle where it first occurs. A driver enable that starts early or ends late is caught by the bench's memory model, which times data setup, pulse width and bus overlap in nanoseconds. A lost or stale address or data register only shows up later, when a read-back at the written address or at the scrambled address returns the wrong byte.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration helpers for the asynchronous SRAM controller.
// Assumes all timing figures are positive integers in nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WSETUP,
        S_WPULSE,
        S_WHOLD,
        S_RACC,
        S_RECOV
    } phase_e;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic oe_n;
        logic we_n;
    } mem_ctl_t;

    // Clock count covering a time span, rounded up
    function automatic int clk_count(input int span_ns, input int period_ns);
        return (span_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that measures the length of one controller phase.
// Loading N-1 makes 'last' rise in the N-th cycle after the load.
// Assumes the sequencer loads it on every phase entry that needs timing.
module asram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Cycle sequencer: accepts requests, steps through setup, pulse, hold,
// access and recovery phases, and registers every memory strobe so the
// pins change only at clock edges and never glitch.
// Assumes ASU, WP and RD are at least 1 and fit in CW bits.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CW  = 4,
    parameter int ASU = 3,
    parameter int WP  = 10,
    parameter int RD  = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          req,
    input  logic          wr,
    input  logic          timer_last,
    output logic          timer_load,
    output logic [CW-1:0] timer_val,
    output logic          accept,
    output logic          ready,
    output logic          capture_rd,
    output mem_ctl_t      ctl,
    output logic          dq_drive
);
    localparam mem_ctl_t CTL_OFF  = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1, we_n: 1'b1};
    localparam mem_ctl_t CTL_SEL  = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b1};
    localparam mem_ctl_t CTL_WR   = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b0};
    localparam mem_ctl_t CTL_RD   = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b0, we_n: 1'b1};

    phase_e   state_q, state_nxt;
    mem_ctl_t ctl_nxt;

    // Next phase and timer loads
    always_comb begin
        state_nxt  = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (req && !standby) begin
                    accept     = 1'b1;
                    timer_load = 1'b1;
                    if (wr) begin
                        state_nxt = S_WSETUP;
                        timer_val = CW'(ASU - 1);
                    end else begin
                        state_nxt = S_RACC;
                        timer_val = CW'(RD - 1);
                    end
                end
            end
            S_WSETUP: begin
                if (timer_last) begin
                    state_nxt  = S_WPULSE;
                    timer_load = 1'b1;
                    timer_val  = CW'(WP - 1);
                end
            end
            S_WPULSE: if (timer_last) state_nxt = S_WHOLD;
            S_WHOLD:  state_nxt = S_RECOV;
            S_RACC:   if (timer_last) state_nxt = S_RECOV;
            S_RECOV:  state_nxt = S_IDLE;
            default:  state_nxt = S_IDLE;
        endcase
    end

    // Strobe levels that belong to the next phase
    always_comb begin
        case (state_nxt)
            S_IDLE:   ctl_nxt = standby ? CTL_OFF : CTL_SEL;
            S_WSETUP: ctl_nxt = CTL_SEL;
            S_WPULSE: ctl_nxt = CTL_WR;
            S_WHOLD:  ctl_nxt = CTL_SEL;
            S_RACC:   ctl_nxt = CTL_RD;
            default:  ctl_nxt = CTL_OFF;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_nxt;
    end

    // Registered memory strobes and bus driver enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl      <= CTL_OFF;
            dq_drive <= 1'b0;
        end else begin
            ctl      <= ctl_nxt;
            dq_drive <= (state_q == S_WPULSE && state_nxt == S_WPULSE) ||
                        (state_nxt == S_WHOLD);
        end
    end

    assign ready      = (state_q == S_IDLE) && !standby;
    assign capture_rd = (state_q == S_RACC) && timer_last;

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
// Data path: holds the captured address and write byte for the whole
// cycle, and registers the returned byte with its one-clock strobe.
// Assumes 'accept' and 'capture_rd' are single-cycle pulses.
module asram_dpath #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          capture_rd,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    // Capture request fields on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= addr;
            mem_dq_out <= wdata;
        end
    end

    // Register read data on the last access cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture_rd;
            if (capture_rd)
                rdata <= mem_dq_in;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM controller. Derives the phase lengths from
// the clock period and the memory timing figures, then joins the phase
// timer, the sequencer and the data path.
// Assumes output enable stays high during writes, so the write pulse only
// has to meet the pulse width and the data setup after the driver turns on.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 4,
    parameter int T_ACC_NS  = 55,
    parameter int T_RCYC_NS = 55,
    parameter int T_WCYC_NS = 55,
    parameter int T_AWE_NS  = 45,
    parameter int T_PW_NS   = 40,
    parameter int T_DSU_NS  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              req,
    output logic              ready,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Write pulse: meets the width, and the setup counted from its 2nd cycle
    localparam int WP  = max2(clk_count(T_PW_NS, CLK_NS), clk_count(T_DSU_NS, CLK_NS) + 1);
    // Setup: covers address-to-write-end and the full write cycle (pulse + hold)
    localparam int ASU = max2(1, max2(clk_count(T_AWE_NS, CLK_NS) - WP,
                                      clk_count(T_WCYC_NS, CLK_NS) - WP - 1));
    // Access: covers access time and the read cycle (with recovery)
    localparam int RD  = max2(1, max2(clk_count(T_ACC_NS, CLK_NS),
                                      clk_count(T_RCYC_NS, CLK_NS) - 1));
    localparam int CW  = $clog2(max2(ASU, max2(WP, RD)) + 1);

    logic          timer_load;
    logic [CW-1:0] timer_val;
    logic          timer_last;
    logic          accept;
    logic          capture_rd;
    mem_ctl_t      ctl;

    asram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .last     (timer_last)
    );

    asram_seq #(.CW(CW), .ASU(ASU), .WP(WP), .RD(RD)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .req        (req),
        .wr         (wr),
        .timer_last (timer_last),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .accept     (accept),
        .ready      (ready),
        .capture_rd (capture_rd),
        .ctl        (ctl),
        .dq_drive   (mem_dq_drive)
    );

    asram_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .addr       (addr),
        .wdata      (wdata),
        .capture_rd (capture_rd),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    assign mem_cs1_n = ctl.cs1_n;
    assign mem_cs2   = ctl.cs2;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for asram_ctrl, attached by bind. Observes ports only.
module asram_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic standby,
    input logic req,
    input logic ready,
    input logic rvalid,
    input logic mem_cs1_n,
    input logic mem_cs2,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_drive
);
    // R3
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R3
    we_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_cs1_n) && $past(mem_cs2)));

    // R4
    drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drive |-> mem_oe_n);

    // R4
    drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_drive) |-> (!mem_we_n && $past(!mem_we_n)));

    // R2
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R2
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(!mem_oe_n));

    // R6
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    // R7
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && $past(standby) && $past(!ready) && $past(mem_cs1_n))
            |-> (mem_cs1_n && !mem_cs2));

endmodule

bind asram_ctrl asram_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby      (standby),
    .req          (req),
    .ready        (ready),
    .rvalid       (rvalid),
    .mem_cs1_n    (mem_cs1_n),
    .mem_cs2      (mem_cs2),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_dq_drive (mem_dq_drive)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for asram_ctrl with a timed behavioural memory model.
module asram_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [19:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, rvalid;
    logic [7:0]  rdata;
    logic [19:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_drive;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    asram_ctrl u_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .standby(standby), .req(req), .ready(ready),
        .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    // ---------------- behavioural memory model ----------------
    logic [7:0] store [int];
    logic       rd_mode, wr_sel, rd_ok;
    logic [7:0] rd_val;
    realtime    t_we_fall, t_drv_on;
    realtime    t_rd_end = -1000.0;
    int         viol_timing = 0;
    int         viol_bus = 0;

    assign rd_mode   = !mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n;
    assign wr_sel    = !mem_cs1_n && mem_cs2 && !mem_we_n;
    assign mem_dq_in = (rd_mode && rd_ok) ? rd_val : 8'hEE;

    initial rd_ok = 1'b0;

    function automatic logic [7:0] lookup(input logic [19:0] a);
        return store.exists(int'(a)) ? store[int'(a)] : 8'h00;
    endfunction

    always @(negedge mem_we_n)    t_we_fall = $realtime;
    always @(posedge mem_dq_drive) t_drv_on = $realtime;

    // Commit a write at the end of the select/WE overlap, checking its timing
    always @(negedge wr_sel) begin
        if (!mem_dq_drive || ($realtime - t_drv_on) < 30.0 || ($realtime - t_we_fall) < 40.0)
            viol_timing++;
        else
            store[int'(mem_addr)] = mem_dq_out;
    end

    // Output valid only after the access time
    always @(posedge rd_mode) begin
        rd_ok = 1'b0;
        #55;
        if (rd_mode) begin
            rd_val = lookup(mem_addr);
            rd_ok  = 1'b1;
        end
    end

    always @(negedge rd_mode) begin
        rd_ok    = 1'b0;
        t_rd_end = $realtime;
    end

    // Bus overlap: controller drive while memory drives or is turning off
    always @(negedge clk) begin
        if (rst_n && mem_dq_drive && (rd_mode || ($realtime - t_rd_end) < 20.0))
            viol_bus++;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Present a request at a falling edge; return just after the accepting edge
    task automatic issue(input logic w, input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        chk("R6 ready before request", int'(ready), 1);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        req = 1'b0; wr = !w; addr = ~a; wdata = ~d;   // R8: scramble after accept
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 cs1_n", int'(mem_cs1_n), 1);
        chk("R1 cs2", int'(mem_cs2), 0);
        chk("R1 oe_n", int'(mem_oe_n), 1);
        chk("R1 we_n", int'(mem_we_n), 1);
        chk("R1 drive", int'(mem_dq_drive), 0);
        chk("R1 rvalid", int'(rvalid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_idle;
        chk("R9 cs1_n", int'(mem_cs1_n), 0);
        chk("R9 cs2", int'(mem_cs2), 1);
        chk("R9 oe_n", int'(mem_oe_n), 1);
        chk("R9 we_n", int'(mem_we_n), 1);
        chk("R9 ready", int'(ready), 1);
    endtask

    task automatic t_write(input logic [19:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            chk("R3 oe_n", int'(mem_oe_n), 1);
            chk("R3 we_n", int'(mem_we_n), (i >= 4 && i <= 13) ? 0 : 1);
            chk("R3 cs1_n", int'(mem_cs1_n), (i == 15) ? 1 : 0);
            chk("R6 cs2", int'(mem_cs2), (i == 15) ? 0 : 1);
            chk("R4 drive", int'(mem_dq_drive), (i >= 5 && i <= 14) ? 1 : 0);
            chk("R6 ready", int'(ready), (i >= 16) ? 1 : 0);
            chk("R10 rvalid", int'(rvalid), 0);
            if (i >= 4 && i <= 14)
                chk("R8 addr", int'(mem_addr), int'(a));
        end
    endtask

    task automatic t_read(input logic [19:0] a, input logic [7:0] exp, input bool_standby_mid);
        issue(1'b0, a, 8'h00);
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            if (bool_standby_mid && i == 3) standby = 1'b1;
            chk("R2 oe_n", int'(mem_oe_n), (i <= 14) ? 0 : 1);
            chk("R2 we_n", int'(mem_we_n), 1);
            chk("R4 drive", int'(mem_dq_drive), 0);
            chk("R2 rvalid", int'(rvalid), (i == 15) ? 1 : 0);
            if (i == 15) chk("R2 rdata", int'(rdata), int'(exp));
            if (i == 16 && bool_standby_mid) begin
                chk("R7 cs1_n", int'(mem_cs1_n), 1);
                chk("R7 cs2", int'(mem_cs2), 0);
                chk("R7 ready", int'(ready), 0);
            end else begin
                chk("R6 cs1_n", int'(mem_cs1_n), (i == 15) ? 1 : 0);
                chk("R6 ready", int'(ready), (i >= 16) ? 1 : 0);
            end
        end
    endtask

    task automatic t_standby_idle;
        @(negedge clk);
        standby = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 cs1_n", int'(mem_cs1_n), 1);
        chk("R7 cs2", int'(mem_cs2), 0);
        chk("R7 ready", int'(ready), 0);
        req = 1'b1; wr = 1'b1; addr = 20'h000AA; wdata = 8'h77;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R7 we_n", int'(mem_we_n), 1);
            chk("R7 oe_n", int'(mem_oe_n), 1);
        end
        req = 1'b0;
        @(negedge clk);
        standby = 1'b0;
        @(negedge clk);
        t_idle();
        t_read(20'h000AA, 8'h00, 1'b0);                 // R7: nothing was written
    endtask

    // Watchdog
    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_write(20'h12345, 8'hA5);
        t_read(20'h12345, 8'hA5, 1'b0);                 // R5 read-back
        t_read(20'hEDCBA, 8'h00, 1'b0);                 // R8 scrambled address untouched
        t_write(20'hFFFFF, 8'h3C);
        t_write(20'h00000, 8'hC3);
        t_read(20'hFFFFF, 8'h3C, 1'b0);                 // R5
        t_read(20'h00000, 8'hC3, 1'b0);                 // R5
        t_write(20'h12345, 8'h5A);
        t_read(20'h12345, 8'h5A, 1'b0);                 // R5 overwrite
        t_standby_idle();
        t_read(20'h12345, 8'h5A, 1'b1);                 // R7 standby mid-cycle
        @(negedge clk);
        standby = 1'b0;
        repeat (2) @(negedge clk);
        t_idle();
        chk("R5 model timing violations", viol_timing, 0);
        chk("R4 model bus overlaps", viol_bus, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule